// File: doc/BRIEF.md
# Shift Execution Unit with Condition Code

This block is the shift stage of a 64-bit integer pipeline. In one operation it shifts left or right, either logically or arithmetically, a 32-bit operand, a 64-bit operand, or a 64-bit value formed from an even/odd register pair. It also rotates a 32-bit or a 64-bit operand to the left. The shift amount comes from a base-plus-displacement field. When the base field is zero, the displacement alone gives the amount. Otherwise the base register value plus the sign-extended displacement gives it. In both cases only the low six bits count, so 32-bit operands can be shifted by 32 to 63.

Each accepted operation produces one registered result one cycle later. The result carries two half-word write enables, which tell the register file where to store it. Arithmetic shifts also return a 2-bit condition code with a `cc_valid` strobe. Left arithmetic shifts keep the sign bit and signal overflow with code 3. Logical shifts and rotates leave the stored condition code alone, so `cc_valid` stays low for them.

Operation codes on `in_op` are as follows:

| Code | Operation |
|------|-----------|
| 0 | 32-bit arithmetic left |
| 1 | 64-bit arithmetic left |
| 2 | 32-bit logical left |
| 3 | 64-bit logical left |
| 4 | 32-bit arithmetic right |
| 5 | 64-bit arithmetic right |
| 6 | 32-bit logical right |
| 7 | 64-bit logical right |
| 8 | pair arithmetic left |
| 9 | pair logical left |
| 10 | pair arithmetic right |
| 11 | pair logical right |
| 12 | 32-bit rotate left |
| 13 | 64-bit rotate left |
| 14, 15 | unused |

Top module: `shift_cc_unit`

## Requirements
- R1: The shift amount is `disp[5:0]` when `base_zero` is 1. Otherwise it is bits [5:0] of `base_val` plus `disp` sign-extended to 64 bits. This holds for every operation code.
- R2: Codes 2 and 6 shift `op_a[31:0]` left or right with zero fill. Any amount of 32 or more gives zero. The result appears in `result[31:0]`, with `result[63:32]` = 0, `wr_lo` = 1 and `wr_hi` = 0. Every 32-bit code (0, 2, 4, 6, 12) uses these same enables.
- R3: Code 4 sign-extends `op_a[31:0]` and then shifts it right. An amount of 32 or more gives 32 copies of bit 31.
- R4: Arithmetic left shifts (codes 0, 1, 8) return the shifted value with its sign position replaced by the operand's sign bit. The sign position is bit 31 for code 0 and bit 63 otherwise.
- R5: An arithmetic left shift by `n` gives condition code 3 when any of the `n` bits just below the sign bit differs from the sign bit. Positions below bit 0 count as zero.
- R6: Without overflow, arithmetic shifts (codes 0, 1, 4, 5, 8, 10) give condition code 0 for a zero result, 1 for a negative result and 2 for a positive result. The sign is judged at the operation's width. Right shifts never give 3.
- R7: Pair codes 8 to 11 operate on {`op_a[31:0]`, `op_b`}. `result[63:32]` is the new even-register word and `result[31:0]` the new odd-register word. Both enables are 1.
- R8: Code 12 rotates `op_a[31:0]` left by the amount modulo 32. Code 13 rotates `op_a` left by the full amount. Both set `wr_lo` = 1; `wr_hi` is 0 for code 12 and 1 for code 13.
- R9: `cc_valid` is 1 only for the arithmetic codes. For logical shifts and rotates it is 0 and `cc` reads 0.
- R10: The outputs register one cycle after `in_valid`. `out_valid` follows `in_valid` with that delay. Reset clears every output. Codes 14 and 15 produce `out_valid` with zero result, no write enable and no condition code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Operation code (see table above) |
| op_a | input | 64 | Single operand; low word is the even register for pair codes |
| op_b | input | 32 | Odd-register word for pair codes |
| base_zero | input | 1 | Base field is zero |
| base_val | input | 64 | Base register value |
| disp | input | DISP_W | Signed displacement |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Shift or rotate result |
| wr_hi | output | 1 | Write enable for result[63:32] |
| wr_lo | output | 1 | Write enable for result[31:0] |
| cc | output | 2 | Condition code |
| cc_valid | output | 1 | Condition code should be stored |

## Verification
The bench builds the unit with its default 20-bit displacement. Negative displacements against large base values then make the 6-bit amount wrap, and amounts of 32 to 63 become reachable for the 32-bit codes. Directed vectors hit the amount edges 0, 31, 32 and 63, overflow on both sides of the sign, and the pair split. A long random stream covers every code, including the two unused ones, back to back and across idle gaps.

// File: rtl/shc_pkg.sv
package shc_pkg;

    localparam int XLEN = 64;
    localparam int HLEN = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);

    typedef enum logic [3:0] {
        OP_ASHL32 = 4'd0,
        OP_ASHL64 = 4'd1,
        OP_LSHL32 = 4'd2,
        OP_LSHL64 = 4'd3,
        OP_ASHR32 = 4'd4,
        OP_ASHR64 = 4'd5,
        OP_LSHR32 = 4'd6,
        OP_LSHR64 = 4'd7,
        OP_PASHL  = 4'd8,
        OP_PLSHL  = 4'd9,
        OP_PASHR  = 4'd10,
        OP_PLSHR  = 4'd11,
        OP_ROTL32 = 4'd12,
        OP_ROTL64 = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } shc_op_e;

    typedef enum logic [1:0] {
        SZ_WORD  = 2'd0,
        SZ_DWORD = 2'd1,
        SZ_PAIR  = 2'd2
    } shc_size_e;

    typedef enum logic [1:0] {
        K_LOGIC = 2'd0,
        K_ARITH = 2'd1,
        K_ROT   = 2'd2
    } shc_kind_e;

    typedef struct packed {
        logic      legal;
        shc_size_e size;
        shc_kind_e kind;
        logic      left;
    } shc_dec_t;

    typedef struct packed {
        logic [XLEN-1:0] data;
        logic            wr_hi;
        logic            wr_lo;
        logic [1:0]      cc;
        logic            cc_ok;
    } shc_res_t;

    function automatic shc_dec_t shc_decode(shc_op_e op);
        shc_dec_t d;
        d = '{legal: 1'b1, size: SZ_DWORD, kind: K_LOGIC, left: 1'b0};
        case (op)
            OP_ASHL32: d = '{1'b1, SZ_WORD,  K_ARITH, 1'b1};
            OP_ASHL64: d = '{1'b1, SZ_DWORD, K_ARITH, 1'b1};
            OP_LSHL32: d = '{1'b1, SZ_WORD,  K_LOGIC, 1'b1};
            OP_LSHL64: d = '{1'b1, SZ_DWORD, K_LOGIC, 1'b1};
            OP_ASHR32: d = '{1'b1, SZ_WORD,  K_ARITH, 1'b0};
            OP_ASHR64: d = '{1'b1, SZ_DWORD, K_ARITH, 1'b0};
            OP_LSHR32: d = '{1'b1, SZ_WORD,  K_LOGIC, 1'b0};
            OP_LSHR64: d = '{1'b1, SZ_DWORD, K_LOGIC, 1'b0};
            OP_PASHL:  d = '{1'b1, SZ_PAIR,  K_ARITH, 1'b1};
            OP_PLSHL:  d = '{1'b1, SZ_PAIR,  K_LOGIC, 1'b1};
            OP_PASHR:  d = '{1'b1, SZ_PAIR,  K_ARITH, 1'b0};
            OP_PLSHR:  d = '{1'b1, SZ_PAIR,  K_LOGIC, 1'b0};
            OP_ROTL32: d = '{1'b1, SZ_WORD,  K_ROT,   1'b1};
            OP_ROTL64: d = '{1'b1, SZ_DWORD, K_ROT,   1'b1};
            default:   d = '{1'b0, SZ_DWORD, K_LOGIC, 1'b0};
        endcase
        return d;
    endfunction

    function automatic logic [1:0] shc_sign_code(logic is_zero, logic is_neg);
        if (is_zero) return 2'd0;
        if (is_neg)  return 2'd1;
        return 2'd2;
    endfunction

endpackage

// File: rtl/shc_amount.sv
module shc_amount
    import shc_pkg::*;
#(
    parameter int DISP_W = 20
) (
    input  logic              base_zero,
    input  logic [XLEN-1:0]   base_val,
    input  logic [DISP_W-1:0] disp,
    output logic [SHW-1:0]    amt
);
    // Carries only travel upward, so the low SHW bits of the full
    // base + sign-extended displacement sum equal this narrow sum.
    logic [SHW-1:0] sum_lo;
    logic           unused_hi;

    assign sum_lo    = base_val[SHW-1:0] + disp[SHW-1:0];
    assign amt       = base_zero ? disp[SHW-1:0] : sum_lo;
    assign unused_hi = ^{base_val[XLEN-1:SHW], disp[DISP_W-1:SHW]};

endmodule

// File: rtl/shc_shift.sv
module shc_shift
    import shc_pkg::*;
(
    input  shc_dec_t        dec,
    input  logic [XLEN-1:0] op_a,
    input  logic [HLEN-1:0] op_b,
    input  logic [SHW-1:0]  amt,
    output logic [XLEN-1:0] work,
    output logic [XLEN-1:0] data
);
    logic [HLEN-1:0] lo_word;
    logic [XLEN-1:0] lsh;
    logic [XLEN-1:0] lsh_keep;
    logic [XLEN-1:0] rsh_log;
    logic [XLEN-1:0] rsh_ari;
    logic [XLEN-1:0] rsh_sel;
    logic [XLEN-1:0] rot_full;
    logic [XLEN-1:0] rot_dup;

    assign lo_word = op_a[HLEN-1:0];

    // Operand formation: every width lives in one 64-bit work word.
    // Left 32-bit shifts sit in the upper half so the sign is bit 63.
    always_comb begin
        case (dec.size)
            SZ_WORD: begin
                if (dec.left)
                    work = {lo_word, {HLEN{1'b0}}};
                else if (dec.kind == K_ARITH)
                    work = {{HLEN{lo_word[HLEN-1]}}, lo_word};
                else
                    work = {{HLEN{1'b0}}, lo_word};
            end
            SZ_PAIR:  work = {lo_word, op_b};
            default:  work = op_a;
        endcase
    end

    assign lsh      = work << amt;
    assign lsh_keep = (dec.kind == K_ARITH) ? {work[XLEN-1], lsh[XLEN-2:0]} : lsh;
    assign rsh_log  = work >> amt;
    assign rsh_ari  = $signed(work) >>> amt;
    assign rsh_sel  = (dec.kind == K_ARITH) ? rsh_ari : rsh_log;

    assign rot_full = (op_a << amt) | (op_a >> (XLEN - int'(amt)));
    assign rot_dup  = {lo_word, lo_word} << amt[SHW-2:0];

    always_comb begin
        if (!dec.legal) begin
            data = '0;
        end else if (dec.kind == K_ROT) begin
            data = (dec.size == SZ_WORD) ? {{HLEN{1'b0}}, rot_dup[XLEN-1:HLEN]} : rot_full;
        end else if (dec.left) begin
            data = (dec.size == SZ_WORD) ? {{HLEN{1'b0}}, lsh_keep[XLEN-1:HLEN]} : lsh_keep;
        end else begin
            data = (dec.size == SZ_WORD) ? {{HLEN{1'b0}}, rsh_sel[HLEN-1:0]} : rsh_sel;
        end
    end

endmodule

// File: rtl/shc_ccgen.sv
module shc_ccgen
    import shc_pkg::*;
(
    input  shc_dec_t        dec,
    input  logic [XLEN-1:0] work,
    input  logic [XLEN-1:0] data,
    input  logic [SHW-1:0]  amt,
    output logic [1:0]      cc,
    output logic            cc_ok
);
    logic [XLEN-1:0] ovf_mask;
    logic [XLEN-1:0] ovf_match;
    logic            ovf;
    logic            res_zero;
    logic            res_neg;

    // Mask covers the sign and the amt bits below it.
    assign ovf_mask  = {XLEN{1'b1}} << (SHW'(XLEN - 1) - amt);
    assign ovf_match = work[XLEN-1] ? ovf_mask : '0;
    assign ovf       = dec.left && ((work & ovf_mask) != ovf_match);

    assign res_zero = (dec.size == SZ_WORD) ? (data[HLEN-1:0] == '0) : (data == '0);
    assign res_neg  = (dec.size == SZ_WORD) ? data[HLEN-1] : data[XLEN-1];

    assign cc_ok = dec.legal && (dec.kind == K_ARITH);

    always_comb begin
        if (!cc_ok)   cc = 2'd0;
        else if (ovf) cc = 2'd3;
        else          cc = shc_sign_code(res_zero, res_neg);
    end

endmodule

// File: rtl/shift_cc_unit.sv
module shift_cc_unit
    import shc_pkg::*;
#(
    parameter int DISP_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic [XLEN-1:0]   op_a,
    input  logic [HLEN-1:0]   op_b,
    input  logic              base_zero,
    input  logic [XLEN-1:0]   base_val,
    input  logic [DISP_W-1:0] disp,
    output logic              out_valid,
    output logic [XLEN-1:0]   result,
    output logic              wr_hi,
    output logic              wr_lo,
    output logic [1:0]        cc,
    output logic              cc_valid
);
    shc_dec_t        dec;
    logic [SHW-1:0]  amt;
    logic [XLEN-1:0] work;
    shc_res_t        nxt;
    shc_res_t        held;

    assign dec = shc_decode(shc_op_e'(in_op));

    shc_amount #(.DISP_W(DISP_W)) u_amount (
        .base_zero (base_zero),
        .base_val  (base_val),
        .disp      (disp),
        .amt       (amt)
    );

    shc_shift u_shift (
        .dec  (dec),
        .op_a (op_a),
        .op_b (op_b),
        .amt  (amt),
        .work (work),
        .data (nxt.data)
    );

    shc_ccgen u_ccgen (
        .dec   (dec),
        .work  (work),
        .data  (nxt.data),
        .amt   (amt),
        .cc    (nxt.cc),
        .cc_ok (nxt.cc_ok)
    );

    assign nxt.wr_lo = dec.legal;
    assign nxt.wr_hi = dec.legal && (dec.size != SZ_WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            held      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) held <= nxt;
            else          held <= '{data: held.data, default: '0};
        end
    end

    assign result   = held.data;
    assign wr_hi    = held.wr_hi;
    assign wr_lo    = held.wr_lo;
    assign cc       = held.cc;
    assign cc_valid = held.cc_ok;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);  // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !cc_valid && !wr_hi && !wr_lo);  // R10
    AST_WORD_ENABLES: assert property (@(posedge clk) disable iff (rst)
        in_valid && dec.legal && dec.size == SZ_WORD |=> wr_lo && !wr_hi && result[XLEN-1:HLEN] == '0);  // R2
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_op == 4'd1 |=> result[XLEN-1] == $past(op_a[XLEN-1]));  // R4
    AST_RIGHT_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        in_valid && dec.kind == K_ARITH && !dec.left |=> cc != 2'd3);  // R6
    AST_NO_CC_LOGIC: assert property (@(posedge clk) disable iff (rst)
        in_valid && dec.kind != K_ARITH |=> !cc_valid && cc == 2'd0);  // R9
    AST_PAIR_BOTH: assert property (@(posedge clk) disable iff (rst)
        in_valid && dec.legal && dec.size == SZ_PAIR |=> wr_hi && wr_lo);  // R7

endmodule

// File: tb/shift_cc_unit_bench.sv
module shift_cc_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [63:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        base_zero = 1'b1;
    logic [63:0] base_val = '0;
    logic [19:0] disp = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        wr_hi;
    logic        wr_lo;
    logic [1:0]  cc;
    logic        cc_valid;

    always #5 clk = ~clk;

    shift_cc_unit u_shift_cc_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .op_a(op_a), .op_b(op_b), .base_zero(base_zero), .base_val(base_val),
        .disp(disp), .out_valid(out_valid), .result(result), .wr_hi(wr_hi),
        .wr_lo(wr_lo), .cc(cc), .cc_valid(cc_valid)
    );

    typedef struct {
        logic [63:0] r;
        logic        whi;
        logic        wlo;
        logic [1:0]  c;
        logic        cv;
        string       tag;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    fails = 0;
    bit    finished = 0;
    string cur_tag = "";

    function automatic int amt_of(logic bz, logic [63:0] bv, logic [19:0] d);
        logic [63:0] s;
        s = bv + {{44{d[19]}}, d};
        return bz ? int'(d[5:0]) : int'(s[5:0]);
    endfunction

    function automatic bit ovf_chk(logic [63:0] v, int w, int sh);
        for (int i = 1; i <= sh; i++) begin
            int   p;
            logic b;
            p = w - 1 - i;
            b = (p >= 0) ? v[p] : 1'b0;
            if (b != v[w-1]) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [1:0] sign_cc(logic [63:0] v, int w);
        logic z;
        z = (w == 32) ? (v[31:0] == 32'h0) : (v == 64'h0);
        if (z) return 2'd0;
        return v[w-1] ? 2'd1 : 2'd2;
    endfunction

    function automatic exp_t model(int op, logic [63:0] a, logic [31:0] b,
                                   logic bz, logic [63:0] bv, logic [19:0] d);
        exp_t        e;
        int          sh;
        int          k;
        logic [31:0] a32;
        logic [31:0] r32;
        logic [63:0] v;
        logic [63:0] r64;
        sh  = amt_of(bz, bv, d);
        a32 = a[31:0];
        v   = (op >= 8 && op <= 11) ? {a[31:0], b} : a;
        e.r = '0; e.whi = 1'b1; e.wlo = 1'b1; e.c = 2'd0; e.cv = 1'b0;
        e.tag = "R10";
        case (op)
            0: begin
                r32 = (sh >= 32) ? 32'h0 : (a32 << sh);
                r32[31] = a32[31];
                e.r = {32'h0, r32}; e.whi = 1'b0; e.cv = 1'b1;
                e.c = ovf_chk({32'h0, a32}, 32, sh) ? 2'd3 : sign_cc({32'h0, r32}, 32);
                e.tag = "R4 R5 R6";
            end
            1, 8: begin
                r64 = v << sh;
                r64[63] = v[63];
                e.r = r64; e.cv = 1'b1;
                e.c = ovf_chk(v, 64, sh) ? 2'd3 : sign_cc(r64, 64);
                e.tag = (op == 8) ? "R7 R5" : "R4 R5 R6";
            end
            2, 6: begin
                if (sh >= 32)     r32 = 32'h0;
                else if (op == 2) r32 = a32 << sh;
                else              r32 = a32 >> sh;
                e.r = {32'h0, r32}; e.whi = 1'b0;
                e.tag = "R2 R9";
            end
            3, 9: begin e.r = v << sh; e.tag = (op == 9) ? "R7 R9" : "R1 R9"; end
            7, 11: begin e.r = v >> sh; e.tag = (op == 11) ? "R7 R9" : "R1 R9"; end
            4: begin
                if (sh >= 32) r32 = {32{a32[31]}};
                else          r32 = $signed(a32) >>> sh;
                e.r = {32'h0, r32}; e.whi = 1'b0; e.cv = 1'b1;
                e.c = sign_cc({32'h0, r32}, 32);
                e.tag = "R3 R6";
            end
            5, 10: begin
                r64 = $signed(v) >>> sh;
                e.r = r64; e.cv = 1'b1; e.c = sign_cc(r64, 64);
                e.tag = (op == 10) ? "R7 R6" : "R6";
            end
            12: begin
                k = sh % 32;
                r32 = (k == 0) ? a32 : ((a32 << k) | (a32 >> (32 - k)));
                e.r = {32'h0, r32}; e.whi = 1'b0;
                e.tag = "R8 R9";
            end
            13: begin
                e.r = (sh == 0) ? a : ((a << sh) | (a >> (64 - sh)));
                e.tag = "R8 R9";
            end
            default: begin e.whi = 1'b0; e.wlo = 1'b0; e.tag = "R10"; end
        endcase
        return e;
    endfunction

    task automatic finish_up();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Expectation capture at the edge where the design samples its inputs.
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
        end else if (in_valid) begin
            exp_t e;
            e = model(int'(in_op), op_a, op_b, base_zero, base_val, disp);
            if (cur_tag != "") e.tag = {cur_tag, " ", e.tag};
            q.push_back(e);
        end
    end

    // Comparison away from the active edge.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (out_valid) begin
                checks++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL R10 out_valid: got 1 exp 0");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (result !== e.r || wr_hi !== e.whi || wr_lo !== e.wlo ||
                        cc !== e.c || cc_valid !== e.cv) begin
                        fails++;
                        $display("FAIL %s: got r=%h hi=%b lo=%b cc=%0d cv=%b exp r=%h hi=%b lo=%b cc=%0d cv=%b",
                                 e.tag, result, wr_hi, wr_lo, cc, cc_valid,
                                 e.r, e.whi, e.wlo, e.c, e.cv);
                    end
                end
            end else if (q.size() != 0) begin
                checks++;
                fails++;
                $display("FAIL R10 out_valid: got 0 exp 1");
                q.delete();
            end
        end
    end

    task automatic drive(int op, logic [63:0] a, logic [31:0] b, logic bz,
                         logic [63:0] bv, logic [19:0] d, string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        in_op     = 4'(op);
        op_a      = a;
        op_b      = b;
        base_zero = bz;
        base_val  = bv;
        disp      = d;
        cur_tag   = tag;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            cur_tag  = "";
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: got timeout exp completion");
            finish_up();
        end
    end

    initial begin
        // R10: reset wins over a valid request.
        in_valid = 1'b1;
        in_op    = 4'd13;
        op_a     = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 64'h0 || wr_hi !== 1'b0 ||
            wr_lo !== 1'b0 || cc !== 2'd0 || cc_valid !== 1'b0) begin
            fails++;
            $display("FAIL R10 reset: got v=%b r=%h hi=%b lo=%b cc=%0d cv=%b exp all zero",
                     out_valid, result, wr_hi, wr_lo, cc, cc_valid);
        end
        in_valid = 1'b0;
        rst = 1'b0;
        idle(1);

        // R1: amount from displacement alone, and from base plus negative displacement.
        drive(3, 64'h1, 0, 1'b1, 64'hFFFF, 20'h00047, "R1");
        drive(3, 64'h1, 0, 1'b0, 64'd100, -20'sd30, "R1");
        drive(7, 64'h8000_0000_0000_0000, 0, 1'b0, 64'hFFFF_FFFF_FFFF_FFC1, 20'h00000, "R1");
        // R2: 32-bit logical at 0, 4, 31, 32, 63.
        drive(2, 64'hFFFF_FFFF_8000_0001, 0, 1'b1, 0, 20'd4, "R2");
        drive(2, 64'h1234_5678, 0, 1'b1, 0, 20'd32, "R2");
        drive(6, 64'h8765_4321, 0, 1'b1, 0, 20'd31, "R2");
        drive(6, 64'h8765_4321, 0, 1'b1, 0, 20'd63, "R2");
        drive(6, 64'hAAAA_5555_8765_4321, 0, 1'b1, 0, 20'd0, "R2");
        // R3: sign fill beyond 31.
        drive(4, 64'h8000_0000, 0, 1'b1, 0, 20'd35, "R3");
        drive(4, 64'h7000_0000, 0, 1'b1, 0, 20'd63, "R3");
        drive(4, 64'h7000_0000, 0, 1'b1, 0, 20'd4, "R3");
        // R4 R5: overflow and sign retention.
        drive(0, 64'h4000_0000, 0, 1'b1, 0, 20'd1, "R5");
        drive(0, 64'hFFFF_FFFF, 0, 1'b1, 0, 20'd40, "R5");
        drive(0, 64'h0, 0, 1'b1, 0, 20'd50, "R6");
        drive(0, 64'hFFFF_FFFF, 0, 1'b1, 0, 20'd31, "R4");
        drive(1, 64'hC000_0000_0000_0000, 0, 1'b1, 0, 20'd1, "R4");
        drive(1, 64'h0000_0000_0000_0001, 0, 1'b1, 0, 20'd63, "R5");
        // R7: pair split.
        drive(8, 64'h0, 32'h4000_0000, 1'b1, 0, 20'd1, "R7");
        drive(10, 64'h8000_0000, 32'h0, 1'b1, 0, 20'd63, "R7");
        drive(11, 64'h1357_9BDF, 32'h2468_ACE0, 1'b1, 0, 20'd32, "R7");
        drive(9, 64'h1357_9BDF, 32'h2468_ACE0, 1'b1, 0, 20'd8, "R7");
        // R8: rotates.
        drive(12, 64'h8000_0001, 0, 1'b1, 0, 20'd33, "R8");
        drive(13, 64'hF000_0000_0000_000F, 0, 1'b1, 0, 20'd4, "R8");
        // R10: unused codes.
        drive(14, 64'hFFFF, 32'hFFFF, 1'b1, 0, 20'd3, "R10");
        drive(15, 64'hFFFF, 32'hFFFF, 1'b1, 0, 20'd3, "R10");
        idle(2);

        for (int n = 0; n < 600; n++) begin
            logic [63:0] ra;
            ra = {$urandom(), $urandom()};
            if (n % 5 == 0) ra = {$urandom_range(0, 1) == 1 ? 32'hFFFF_FFFF : 32'h0,
                                  $urandom_range(0, 1) == 1 ? 32'hFFFF_FFF0 : 32'h0000_000F};
            drive($urandom_range(0, 15), ra, $urandom(), 1'($urandom_range(0, 1)),
                  {$urandom(), $urandom()}, 20'($urandom()), "");
            if (n % 37 == 0) idle(1);
        end
        idle(3);
        finish_up();
    end

endmodule